// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the word address presented to a synchronous burst memory array. On a rising clock edge where the chip is enabled and either of two start strobes is high (one driven from the processor side, one from the memory-controller side), it captures the external address and begins a new burst at beat zero. Every later edge with the advance input high moves the burst on by one beat; only the lowest address bits change, so the burst wraps within its own aligned group of four words.

The order of the low bits within a burst is either linear (counting up from the starting word and wrapping) or interleaved (starting word XORed with the beat number). The order is sampled at the edge that starts the burst and held until the next start. Bursting is optional: a host may start a fresh address on every cycle with no idle cycles between them. All control and address inputs are sampled on the rising edge; the current address and beat index come straight from registers.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is asserted (rst_n low) and after its release with no further inputs, cur_addr and beat are both zero.
- R2: A rising edge with chip_en high and strobe_proc or strobe_ctrl high sets cur_addr to ext_addr and beat to 0 after that edge.
- R3: A start strobe sampled while chip_en is low is ignored: cur_addr and beat hold their values.
- R4: An edge with advance high and no accepted start raises beat by one, modulo 4 (beat 3 wraps to 0).
- R5: With linear order (order_sel = 0 at the start edge), the low 2 bits of cur_addr equal (starting low bits + beat) modulo 4.
- R6: With interleaved order (order_sel = 1 at the start edge), the low 2 bits of cur_addr equal the starting low bits XOR beat.
- R7: Bits above the low 2 of cur_addr do not change on any edge without an accepted start.
- R8: An edge with neither an accepted start nor advance leaves cur_addr and beat unchanged.
- R9: When an accepted start and advance are high on the same edge, the new address is loaded and beat is 0.
- R10: Accepted starts on consecutive edges each load their own address, with no cycle lost between them.
- R11: Changing order_sel during a burst has no effect; the order chosen at the start edge applies to all its beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_en | input | 1 | Enables acceptance of either start strobe |
| strobe_proc | input | 1 | Processor-side burst start |
| strobe_ctrl | input | 1 | Controller-side burst start |
| advance | input | 1 | Steps the burst by one beat |
| order_sel | input | 1 | 0 = linear order, 1 = interleaved order |
| ext_addr | input | ADDR_W | External word address |
| cur_addr | output | ADDR_W | Current internal address |
| beat | output | BEAT_W | Beat index within the burst |

## Verification
The bench builds the block with ADDR_W = 8 and the default BEAT_W = 2, so every address is small enough to read in a failure line while six upper bits remain to show that wrapping never leaks out of the low pair. Both orders are swept over all four starting words through a full burst and a wrap, which exercises every entry of the linear and interleaved maps. The narrow address also lets back-to-back starts, disabled strobes and start-plus-advance collisions be placed on addresses whose upper and lower parts differ.

// File: rtl/bas_pkg.sv
package bas_pkg;

   typedef enum logic {
      ORD_LINEAR     = 1'b0,
      ORD_INTERLEAVE = 1'b1
   } order_e;

   typedef enum logic [1:0] {
      ACT_HOLD  = 2'd0,
      ACT_START = 2'd1,
      ACT_STEP  = 2'd2
   } action_e;

endpackage

// File: rtl/bas_start_ctrl.sv
module bas_start_ctrl
   import bas_pkg::*;
(
   input  logic    chip_en,
   input  logic    strobe_proc,
   input  logic    strobe_ctrl,
   input  logic    advance,
   output action_e action
);

   logic proc_ok;
   logic ctrl_ok;

   assign proc_ok = strobe_proc & chip_en;
   assign ctrl_ok = strobe_ctrl & chip_en;

   // a start beats an advance on the same edge
   always_comb begin
      if (proc_ok || ctrl_ok)
         action = ACT_START;
      else if (advance)
         action = ACT_STEP;
      else
         action = ACT_HOLD;
   end

endmodule

// File: rtl/bas_beat_counter.sv
module bas_beat_counter
   import bas_pkg::*;
#(
   parameter int BEAT_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  action_e           action,
   output logic [BEAT_W-1:0] beat_q
);

   localparam logic [BEAT_W-1:0] BEAT_ONE = BEAT_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         beat_q <= '0;
      else begin
         case (action)
            ACT_START: beat_q <= '0;
            ACT_STEP:  beat_q <= beat_q + BEAT_ONE;
            default:   beat_q <= beat_q;
         endcase
      end
   end

endmodule

// File: rtl/bas_order_map.sv
module bas_order_map
   import bas_pkg::*;
#(
   parameter int BEAT_W         = 2,
   parameter bit HAS_INTERLEAVE = 1'b1
) (
   input  logic [BEAT_W-1:0] start_low,
   input  logic [BEAT_W-1:0] beat,
   input  order_e            order,
   output logic [BEAT_W-1:0] low_addr
);

   logic [BEAT_W-1:0] lin_low;

   assign lin_low = start_low + beat;

   generate
      if (HAS_INTERLEAVE) begin : g_both
         logic [BEAT_W-1:0] ilv_low;
         for (genvar i = 0; i < BEAT_W; i++) begin : g_bit
            assign ilv_low[i] = start_low[i] ^ beat[i];
         end
         assign low_addr = (order == ORD_INTERLEAVE) ? ilv_low : lin_low;
      end else begin : g_lin
         logic unused_order;
         assign unused_order = order;
         assign low_addr = lin_low;
      end
   endgenerate

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
   import bas_pkg::*;
#(
   parameter int ADDR_W         = 19,
   parameter int BEAT_W         = 2,
   parameter bit HAS_INTERLEAVE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              chip_en,
   input  logic              strobe_proc,
   input  logic              strobe_ctrl,
   input  logic              advance,
   input  logic              order_sel,
   input  logic [ADDR_W-1:0] ext_addr,
   output logic [ADDR_W-1:0] cur_addr,
   output logic [BEAT_W-1:0] beat
);

   localparam int UP_W = ADDR_W - BEAT_W;

   generate
      if (BEAT_W < 1 || BEAT_W > 4) begin : g_bad_beat
         $error("burst_addr_seq: BEAT_W must lie in 1..4");
      end
      if (UP_W < 1) begin : g_bad_addr
         $error("burst_addr_seq: ADDR_W must exceed BEAT_W");
      end
   endgenerate

   action_e           action;
   logic [UP_W-1:0]   upper_q;
   logic [BEAT_W-1:0] start_q;
   order_e            order_q;
   logic [BEAT_W-1:0] beat_q;
   logic [BEAT_W-1:0] low_addr;

   bas_start_ctrl u_start (
      .chip_en     (chip_en),
      .strobe_proc (strobe_proc),
      .strobe_ctrl (strobe_ctrl),
      .advance     (advance),
      .action      (action)
   );

   bas_beat_counter #(.BEAT_W(BEAT_W)) u_beat (
      .clk    (clk),
      .rst_n  (rst_n),
      .action (action),
      .beat_q (beat_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         upper_q <= '0;
         start_q <= '0;
         order_q <= ORD_LINEAR;
      end else if (action == ACT_START) begin
         upper_q <= ext_addr[ADDR_W-1:BEAT_W];
         start_q <= ext_addr[BEAT_W-1:0];
         order_q <= order_e'(order_sel);
      end
   end

   bas_order_map #(.BEAT_W(BEAT_W), .HAS_INTERLEAVE(HAS_INTERLEAVE)) u_map (
      .start_low (start_q),
      .beat      (beat_q),
      .order     (order_q),
      .low_addr  (low_addr)
   );

   assign cur_addr = {upper_q, low_addr};
   assign beat     = beat_q;

endmodule

// File: rtl/bas_checker.sv
module bas_checker #(
   parameter int ADDR_W = 19,
   parameter int BEAT_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              chip_en,
   input logic              strobe_proc,
   input logic              strobe_ctrl,
   input logic              advance,
   input logic [ADDR_W-1:0] ext_addr,
   input logic [ADDR_W-1:0] cur_addr,
   input logic [BEAT_W-1:0] beat
);

   logic start_ok;
   assign start_ok = chip_en & (strobe_proc | strobe_ctrl);

   AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      start_ok |=> (cur_addr == $past(ext_addr)) && (beat == '0)); // R2

   AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!chip_en && !advance) |=> $stable(cur_addr) && $stable(beat)); // R3

   AST_BEAT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && !start_ok) |=> beat == BEAT_W'($past(beat) + 1'b1)); // R4

   AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
      !start_ok |=> cur_addr[ADDR_W-1:BEAT_W] == $past(cur_addr[ADDR_W-1:BEAT_W])); // R7

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!start_ok && !advance) |=> $stable(cur_addr) && $stable(beat)); // R8

   AST_START_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (start_ok && advance) |=> beat == '0); // R9

endmodule

bind burst_addr_seq bas_checker #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_bas_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .chip_en     (chip_en),
   .strobe_proc (strobe_proc),
   .strobe_ctrl (strobe_ctrl),
   .advance     (advance),
   .ext_addr    (ext_addr),
   .cur_addr    (cur_addr),
   .beat        (beat)
);

// File: tb/burst_addr_seq_bench.sv
`timescale 1ns/1ps
module burst_addr_seq_bench;

   localparam int AW = 8;
   localparam int BW = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          chip_en = 1'b0;
   logic          strobe_proc = 1'b0;
   logic          strobe_ctrl = 1'b0;
   logic          advance = 1'b0;
   logic          order_sel = 1'b0;
   logic [AW-1:0] ext_addr = '0;
   logic [AW-1:0] cur_addr;
   logic [BW-1:0] beat;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   logic [AW-1:0] exp_addr_q[$];
   logic [BW-1:0] exp_beat_q[$];
   string         exp_tag_q[$];

   logic [AW-BW-1:0] m_up = '0;
   logic [BW-1:0]    m_start = '0;
   logic [BW-1:0]    m_beat = '0;
   logic             m_ilv = 1'b0;

   always #2 clk = ~clk;

   burst_addr_seq #(.ADDR_W(AW), .BEAT_W(BW)) u_burst_addr_seq (
      .clk(clk), .rst_n(rst_n), .chip_en(chip_en),
      .strobe_proc(strobe_proc), .strobe_ctrl(strobe_ctrl),
      .advance(advance), .order_sel(order_sel),
      .ext_addr(ext_addr), .cur_addr(cur_addr), .beat(beat)
   );

   function automatic logic [AW-1:0] model_addr();
      logic [BW-1:0] low;
      if (m_ilv) low = m_start ^ m_beat;
      else       low = BW'((int'(m_start) + int'(m_beat)) % 4);
      return {m_up, low};
   endfunction

   task automatic check(input string tag, input logic [AW-1:0] ga, input logic [BW-1:0] gb,
                        input logic [AW-1:0] ea, input logic [BW-1:0] eb);
      total++;
      if (ga !== ea || gb !== eb) begin
         bad++;
         $display("FAIL %s: addr=%h beat=%0d expected addr=%h beat=%0d", tag, ga, gb, ea, eb);
      end
   endtask

   // driver: applies one cycle of stimulus and queues the expected outcome
   task automatic drive(input logic sp, input logic sc, input logic adv, input logic ce,
                        input logic md, input logic [AW-1:0] a, input string tag);
      @(negedge clk);
      strobe_proc = sp; strobe_ctrl = sc; advance = adv;
      chip_en = ce; order_sel = md; ext_addr = a;
      if (ce && (sp || sc)) begin
         m_up = a[AW-1:BW]; m_start = a[BW-1:0]; m_ilv = md; m_beat = '0;
      end else if (adv) begin
         m_beat = m_beat + 1'b1;
      end
      exp_addr_q.push_back(model_addr());
      exp_beat_q.push_back(m_beat);
      exp_tag_q.push_back(tag);
   endtask

   // monitor: compares one result per edge
   always @(posedge clk) begin
      #1;
      if (rst_n && exp_addr_q.size() > 0)
         check(exp_tag_q.pop_front(), cur_addr, beat,
               exp_addr_q.pop_front(), exp_beat_q.pop_front());
   end

   initial begin
      #40000;
      if (!done) begin
         done = 1'b1;
         bad++; total++;
         $display("FAIL watchdog: run did not finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      // R1 reset state, strobe held during reset
      strobe_proc = 1'b1; chip_en = 1'b1; ext_addr = 8'hFF;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1 in reset", cur_addr, beat, '0, '0);
      strobe_proc = 1'b0; chip_en = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release", cur_addr, beat, '0, '0);

      // R2 R5 R7 linear burst with wrap
      drive(1, 0, 0, 1, 0, 8'hA5, "R2 load proc");
      drive(0, 0, 1, 1, 0, 8'h00, "R5 R4 beat1");
      drive(0, 0, 1, 1, 0, 8'h00, "R5 R7 beat2");
      drive(0, 0, 1, 1, 0, 8'h00, "R5 beat3");
      drive(0, 0, 1, 1, 0, 8'h00, "R4 wrap");
      drive(0, 0, 0, 1, 0, 8'h3C, "R8 idle");
      drive(1, 0, 0, 0, 0, 8'h3C, "R3 proc disabled");
      drive(0, 1, 0, 0, 1, 8'h77, "R3 ctrl disabled");
      drive(1, 1, 0, 0, 0, 8'h11, "R3 both disabled");

      // R6 interleaved via controller strobe, R11 mode flips mid burst
      drive(0, 1, 0, 1, 1, 8'h3E, "R2 R6 load ctrl");
      drive(0, 0, 1, 1, 0, 8'h00, "R6 R11 beat1");
      drive(0, 0, 1, 1, 1, 8'h00, "R6 beat2");
      drive(0, 0, 1, 1, 0, 8'h00, "R6 R11 beat3");

      // R9 start and advance together
      drive(0, 0, 1, 1, 0, 8'h00, "R4 pre");
      drive(1, 0, 1, 1, 0, 8'hC7, "R9 start wins");
      drive(0, 0, 1, 1, 0, 8'h00, "R9 follow");

      // R10 back-to-back starts
      drive(1, 0, 0, 1, 0, 8'h12, "R10 load a");
      drive(0, 1, 0, 1, 1, 8'h6B, "R10 load b");
      drive(1, 1, 1, 1, 0, 8'hF0, "R10 load c");
      drive(0, 1, 0, 1, 0, 8'h81, "R10 load d");

      // sweep: both orders, every starting word, full burst plus wrap
      for (int m = 0; m < 2; m++) begin
         for (int s = 0; s < 4; s++) begin
            drive(1, 0, 0, 1, m[0], 8'(8'h54 + s), m == 0 ? "R5 sweep load" : "R6 sweep load");
            for (int k = 0; k < 5; k++)
               drive(0, 0, 1, 1, 1'b0, 8'hFF, m == 0 ? "R5 sweep step" : "R6 sweep step");
         end
      end

      drive(0, 0, 0, 1, 0, 8'h00, "R8 final idle");
      repeat (3) @(negedge clk);
      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule